// File: doc/BRIEF.md
# Four-Bank Write-Through Register File

This block holds the architectural register values for four parallel execution lanes. The 64 registers are spread across four banks. Register number `r` lives in bank `r mod 4`, at slot `r / 4` inside that bank. An issue stage that expands a vector operation into element operations can therefore stripe consecutive elements across the four lanes, and no lane ever competes with another for a port.

Each lane owns one bank. A lane has three read ports and one write port. Reads are combinational. A write is committed at the rising clock edge. During the cycle in which a write is presented, the incoming value already appears on every read port of that lane that addresses the written register. This same-cycle pass-through is the only forwarding mechanism in the design, so functional units need no separate bypass network.

The ports carry no valid/ready handshake, because a register file port cannot stall: a write enable marks a write, and a read address is always serviced. A lane that addresses a register belonging to another bank is refused. Such a write is dropped, and such a read returns zero.

Top module: `banked_wt_regfile`

## Requirements
- R1: While reset is asserted and after it is released, every register reads as zero until it is written; asserting reset again clears all registers written before.
- R2: A write on lane L with `wr_en[L]`=1 and `wr_addr[L][1:0]`=L stores `wr_data[L]` at the rising edge, and a later read of that register on lane L returns it.
- R3: In the cycle a valid write is presented on lane L, any read port of lane L whose address equals `wr_addr[L]` returns `wr_data[L]` combinationally, before the edge.
- R4: The three read ports of a lane are independent; they may address the same or different registers of the bank in the same cycle.
- R5: All four lanes may write in the same cycle, and each write lands only in its own bank.
- R6: A write on lane L whose address has low two bits not equal to L changes no register and is not passed through to any read port.
- R7: A read port of lane L whose address has low two bits not equal to L returns zero.
- R8: Every register, including register 0, is writable.
- R9: When no write is presented on lane L, the contents of bank L do not change, and a stable read address gives stable read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 4 | Per-lane write enable |
| wr_addr | input | 4x6 | Per-lane write register number |
| wr_data | input | 4x32 | Per-lane write value |
| rd_addr | input | 4x3x6 | Per-lane, per-port read register number |
| rd_data | output | 4x3x32 | Per-lane, per-port read value |

## Verification
The assertions check four behaviours on every cycle. The first is same-cycle pass-through on every lane and port. The second is that a read addressed to another bank returns zero. The third is that a register written in the previous cycle reads back its value. The fourth is that an idle lane with a steady address has steady data. Other properties are shown only by the bench's scenarios. These are that reset clears all 64 entries and that four lanes writing together land in separate banks. They also include that a refused write leaves the target register untouched and that register 0 behaves like any other register.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int unsigned RF_DATA_W = 32;
  localparam int unsigned RF_REGS   = 64;
  localparam int unsigned RF_LANES  = 4;
  localparam int unsigned RF_READS  = 3;
endpackage

// File: rtl/rf_addr_split.sv
module rf_addr_split #(
  parameter int unsigned AW      = 6,
  parameter int unsigned BW      = 2,
  parameter int unsigned LANE_ID = 0
) (
  input  logic [AW-1:0]    reg_num,
  output logic [AW-BW-1:0] slot,
  output logic             own_bank
);
  localparam logic [BW-1:0] MY_BANK = BW'(LANE_ID);

  assign slot     = reg_num[AW-1:BW];
  assign own_bank = (reg_num[BW-1:0] == MY_BANK);
endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int unsigned DW    = 32,
  parameter int unsigned IW    = 4,
  parameter int unsigned NR    = 3,
  localparam int unsigned DEPTH = 1 << IW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [IW-1:0]          widx,
  input  logic [DW-1:0]          wdata,
  input  logic [NR-1:0][IW-1:0]  ridx,
  input  logic [NR-1:0]          rok,
  output logic [NR-1:0][DW-1:0]  rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  for (genvar p = 0; p < NR; p++) begin : g_rd
    always_comb begin
      if (!rok[p])                   rdata[p] = '0;
      else if (we && widx == ridx[p]) rdata[p] = wdata;
      else                           rdata[p] = mem[ridx[p]];
    end
  end
endmodule

// File: rtl/banked_wt_regfile.sv
module banked_wt_regfile
  import regfile_pkg::*;
#(
  parameter int unsigned DATA_W = RF_DATA_W,
  parameter int unsigned REGS   = RF_REGS,
  parameter int unsigned LANES  = RF_LANES,
  parameter int unsigned READS  = RF_READS,
  localparam int unsigned AW    = $clog2(REGS),
  localparam int unsigned BW    = $clog2(LANES),
  localparam int unsigned IW    = AW - BW
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [LANES-1:0]                      wr_en,
  input  logic [LANES-1:0][AW-1:0]              wr_addr,
  input  logic [LANES-1:0][DATA_W-1:0]          wr_data,
  input  logic [LANES-1:0][READS-1:0][AW-1:0]   rd_addr,
  output logic [LANES-1:0][READS-1:0][DATA_W-1:0] rd_data
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [IW-1:0]            w_slot;
    logic                     w_own;
    logic [READS-1:0][IW-1:0] r_slot;
    logic [READS-1:0]         r_own;

    rf_addr_split #(.AW(AW), .BW(BW), .LANE_ID(l)) u_wdec (
      .reg_num (wr_addr[l]),
      .slot    (w_slot),
      .own_bank(w_own)
    );

    for (genvar p = 0; p < READS; p++) begin : g_rdec
      rf_addr_split #(.AW(AW), .BW(BW), .LANE_ID(l)) u_rdec (
        .reg_num (rd_addr[l][p]),
        .slot    (r_slot[p]),
        .own_bank(r_own[p])
      );
    end

    rf_bank #(.DW(DATA_W), .IW(IW), .NR(READS)) u_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (wr_en[l] & w_own),
      .widx (w_slot),
      .wdata(wr_data[l]),
      .ridx (r_slot),
      .rok  (r_own),
      .rdata(rd_data[l])
    );
  end
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES  = 4,
  parameter int unsigned READS  = 3,
  parameter int unsigned AW     = 6,
  parameter int unsigned BW     = 2
) (
  input logic                                    clk,
  input logic                                    rst_n,
  input logic [LANES-1:0]                        wr_en,
  input logic [LANES-1:0][AW-1:0]                wr_addr,
  input logic [LANES-1:0][DATA_W-1:0]            wr_data,
  input logic [LANES-1:0][READS-1:0][AW-1:0]     rd_addr,
  input logic [LANES-1:0][READS-1:0][DATA_W-1:0] rd_data
);
  for (genvar l = 0; l < LANES; l++) begin : g_l
    localparam logic [BW-1:0] LID = BW'(l);
    for (genvar p = 0; p < READS; p++) begin : g_p
      // R3
      a_r3_write_through: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[l] && wr_addr[l][BW-1:0] == LID && rd_addr[l][p] == wr_addr[l])
        |-> rd_data[l][p] == wr_data[l]);
      // R7
      a_r7_foreign_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr[l][p][BW-1:0] != LID) |-> rd_data[l][p] == '0);
      // R2
      a_r2_written_reads_back: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en[l]) && $past(wr_addr[l][BW-1:0]) == LID
         && rd_addr[l][p] == $past(wr_addr[l]) && !wr_en[l])
        |-> rd_data[l][p] == $past(wr_data[l]));
      // R9
      a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en[l]) && !wr_en[l] && $stable(rd_addr[l][p]))
        |-> $stable(rd_data[l][p]));
    end
  end
endmodule

bind banked_wt_regfile rf_checker #(
  .DATA_W(DATA_W), .LANES(LANES), .READS(READS), .AW(AW), .BW(BW)
) u_rf_checker (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .wr_addr(wr_addr),
  .wr_data(wr_data),
  .rd_addr(rd_addr),
  .rd_data(rd_data)
);

// File: tb/test_banked_wt_regfile.sv
`timescale 1ns/1ps
module test_banked_wt_regfile;
  localparam int DW = 32, NL = 4, NR = 3, AW = 6, NREG = 64;

  logic clk = 0;
  logic rst_n = 0;
  logic [NL-1:0]                  wr_en = '0;
  logic [NL-1:0][AW-1:0]          wr_addr = '0;
  logic [NL-1:0][DW-1:0]          wr_data = '0;
  logic [NL-1:0][NR-1:0][AW-1:0]  rd_addr = '0;
  logic [NL-1:0][NR-1:0][DW-1:0]  rd_data;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [NREG];

  always #10 clk = ~clk;

  banked_wt_regfile i_banked_wt_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [DW-1:0] pat(input int r, input int salt);
    return (32'h9E3779B9 * 32'(r + 1 + salt)) ^ 32'(r);
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // rotate registers over ports so every port sees every register of its bank
  task automatic sweep(input string req);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      for (int l = 0; l < NL; l++)
        for (int p = 0; p < NR; p++)
          rd_addr[l][p] = AW'((((i + p * 5) % 16) * 4) + l);
      #1;
      for (int l = 0; l < NL; l++)
        for (int p = 0; p < NR; p++)
          chk(req, rd_data[l][p], model[(((i + p * 5) % 16) * 4) + l]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int r = 0; r < NREG; r++) model[r] = '0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    for (int r = 0; r < NREG; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    // R1: zero while in reset
    rd_addr[0][0] = 6'd0; rd_addr[3][2] = 6'd63;
    #1 chk("R1", rd_data[0][0], '0); chk("R1", rd_data[3][2], '0);
    rst_n = 1;
    sweep("R1");

    // R5 / R8: all lanes write together, covering every register incl. 0
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      for (int l = 0; l < NL; l++) begin
        wr_en[l] = 1'b1;
        wr_addr[l] = AW'(i * 4 + l);
        wr_data[l] = pat(i * 4 + l, 0);
        model[i * 4 + l] = pat(i * 4 + l, 0);
      end
    end
    @(negedge clk); wr_en = '0;
    sweep("R2 R4 R5 R8");

    // R3: pass-through in the write cycle
    @(negedge clk);
    wr_en[2] = 1; wr_addr[2] = 6'd10; wr_data[2] = 32'hDEADBEEF;
    rd_addr[2][0] = 6'd10; rd_addr[2][1] = 6'd6; rd_addr[2][2] = 6'd10;
    #1;
    chk("R3", rd_data[2][0], 32'hDEADBEEF);
    chk("R3", rd_data[2][2], 32'hDEADBEEF);
    chk("R4", rd_data[2][1], model[6]);
    model[10] = 32'hDEADBEEF;
    @(negedge clk); wr_en = '0;
    #1 chk("R2", rd_data[2][0], 32'hDEADBEEF);

    // R8: overwrite register 0 explicitly
    @(negedge clk);
    wr_en[0] = 1; wr_addr[0] = 6'd0; wr_data[0] = 32'h0BADF00D;
    model[0] = 32'h0BADF00D;
    @(negedge clk); wr_en = '0; rd_addr[0][1] = 6'd0;
    #1 chk("R8", rd_data[0][1], 32'h0BADF00D);

    // R6: lane 0 tries to write register 5 (bank 1)
    @(negedge clk);
    wr_en[0] = 1; wr_addr[0] = 6'd5; wr_data[0] = 32'h12345678;
    rd_addr[1][0] = 6'd5; rd_addr[0][2] = 6'd4;
    #1;
    chk("R6", rd_data[1][0], model[5]);
    chk("R6", rd_data[0][2], model[4]);
    @(negedge clk); wr_en = '0;
    #1;
    chk("R6", rd_data[1][0], model[5]);
    chk("R6", rd_data[0][2], model[4]);

    // R7: foreign reads give zero
    @(negedge clk);
    rd_addr[0][1] = 6'd5; rd_addr[3][2] = 6'd0; rd_addr[2][0] = 6'd63;
    #1;
    chk("R7", rd_data[0][1], '0);
    chk("R7", rd_data[3][2], '0);
    chk("R7", rd_data[2][0], '0);

    // R9: idle cycles keep everything
    repeat (5) @(negedge clk);
    sweep("R9");

    // R1: reset clears written contents
    do_reset();
    sweep("R1");
    summary();
  end
endmodule